// File: doc/BRIEF.md
# Colour Lookup Table Loader

This block holds a 256-entry colour lookup table in which each entry is an 8-bit red, green and blue triple. It sits behind a small 32-bit register window, 16 bytes long. Software first writes an entry number to the index register. It then writes the colour components of that entry, one per bus write, to the component register. An internal phase counter steers each component write to red, green or blue in turn. After blue, the counter moves the index on to the next entry, so a whole palette can be loaded with one index write followed by a stream of component writes.

A separate lookup port serves a display pipeline. It takes a pixel index and returns the stored 24-bit colour one clock later. Both registers take their value from the most significant byte of the write data. Every bus read from the window returns zero.

Top module: `clut_loader`

## Requirements
- R1: A write to offset 0x0 loads the current index from wdata[31:24] and sets the component phase to red. The lower 24 data bits have no effect.
- R2: Successive writes to offset 0x4 store wdata[31:24] into the red, green and blue fields of the current entry, in that order. The lookup output is packed as {red[23:16], green[15:8], blue[7:0]}.
- R3: The blue write increments the index modulo 256, so entry 255 is followed by entry 0, and returns the phase to red.
- R4: After reset, entries 0 to 254 read as 0x000000 and entry 255 reads as 0xFFFFFF. The index and phase both start at 0, so the first component write goes to the red field of entry 0.
- R5: A bus read, marked by valid high and write low, returns 0 for any offset. A read changes neither the index, the phase nor the table.
- R6: Writes to any offset other than 0x0 and 0x4 leave the table, the index and the phase unchanged.
- R7: pix_rgb is registered. It shows the entry that pix_idx selected at the previous rising clock edge.
- R8: Suppose a component write and a lookup address the same entry in the same cycle. The lookup then returns the entry as it was before that write, and the new value appears from the next lookup on.
- R9: An index write made part way through an R/G/B sequence abandons the sequence. The next component write goes to the red field of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle, accepted at once |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| pix_idx | input | 8 | Lookup index from the display pipeline |
| pix_rgb | output | 24 | Registered colour of the looked-up entry |

## Verification
The lookup port and the bus loader can touch the same entry in the same clock. The bench provokes this by holding pix_idx on the entry that the behavioural model predicts will be written next, through whole R/G/B sequences. This includes the blue write that moves the index, and it is also done on the 255-to-0 wrap. The bench then expects the pre-write colour in the following cycle and the updated colour in the cycle after. A random phase mixes lookups aimed at the live index with writes to all four offsets and with reads, and checks every clock against the model.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2,
    PH_BAD = 2'd3
  } phase_t;

  // Colour component carried in the most significant byte of a bus word.
  function automatic logic [7:0] top_byte(input logic [31:0] word);
    return word[31:24];
  endfunction

  // Index after a completed triple, wrapping at the table size.
  function automatic logic [7:0] step_index(input logic [7:0] idx);
    return idx + 8'd1;
  endfunction

  // Phase that follows a component write.
  function automatic phase_t step_phase(input phase_t ph);
    case (ph)
      PH_RED:  return PH_GRN;
      PH_GRN:  return PH_BLU;
      default: return PH_RED;
    endcase
  endfunction
endpackage

// File: rtl/clut_regdec.sv
module clut_regdec #(
  parameter int ADDR_W   = 4,
  parameter int IDX_OFS  = 0,
  parameter int COMP_OFS = 4
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              idx_wr,
  output logic              comp_wr
);
  localparam logic [ADDR_W-1:0] IDX_A  = ADDR_W'(IDX_OFS);
  localparam logic [ADDR_W-1:0] COMP_A = ADDR_W'(COMP_OFS);

  logic wr_any;
  assign wr_any  = bus_valid && bus_write;
  assign idx_wr  = wr_any && (bus_addr == IDX_A);
  assign comp_wr = wr_any && (bus_addr == COMP_A);
endmodule

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_wr,
  input  logic        comp_wr,
  input  logic [31:0] wdata,
  output logic [7:0]  cur_idx,
  output phase_t      cur_phase,
  output logic        tbl_we,
  output phase_t      tbl_sel,
  output logic [7:0]  tbl_idx,
  output logic [7:0]  tbl_val,
  output logic        triple_done
);
  logic phase_ok;
  assign phase_ok    = (cur_phase != PH_BAD);
  assign tbl_we      = comp_wr && phase_ok;
  assign tbl_sel     = cur_phase;
  assign tbl_idx     = cur_idx;
  assign tbl_val     = top_byte(wdata);
  assign triple_done = comp_wr && (cur_phase == PH_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_idx   <= '0;
      cur_phase <= PH_RED;
    end else if (idx_wr) begin
      cur_idx   <= top_byte(wdata);
      cur_phase <= PH_RED;
    end else if (comp_wr) begin
      cur_phase <= step_phase(cur_phase);
      if (triple_done) cur_idx <= step_index(cur_idx);
    end
  end
endmodule

// File: rtl/clut_table.sv
module clut_table
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  phase_t                  sel,
  input  logic [IDX_W-1:0]        widx,
  input  logic [COMP_W-1:0]       wval,
  input  logic [IDX_W-1:0]        ridx,
  output logic [NCOMP*COMP_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  for (genvar c = 0; c < NCOMP; c++) begin : g_lane
    logic [COMP_W-1:0] mem [DEPTH];
    logic lane_we;
    assign lane_we = we && (int'(sel) == c);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int e = 0; e < DEPTH; e++)
          mem[e] <= (IDX_W'(e) == LAST) ? {COMP_W{1'b1}} : '0;
        rdata[(NCOMP-1-c)*COMP_W +: COMP_W] <= '0;
      end else begin
        rdata[(NCOMP-1-c)*COMP_W +: COMP_W] <= mem[ridx];
        if (lane_we) mem[widx] <= wval;
      end
    end
  end
endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [7:0]  pix_idx,
  output logic [23:0] pix_rgb
);
  logic       idx_wr, comp_wr, tbl_we, triple_done;
  logic [7:0] cur_idx, tbl_idx, tbl_val;
  phase_t     cur_phase, tbl_sel;

  assign bus_rdata = '0;

  clut_regdec #(.ADDR_W(4), .IDX_OFS(0), .COMP_OFS(4)) u_dec (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .idx_wr(idx_wr), .comp_wr(comp_wr)
  );

  clut_seq u_seq (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .comp_wr(comp_wr),
    .wdata(bus_wdata), .cur_idx(cur_idx), .cur_phase(cur_phase),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx),
    .tbl_val(tbl_val), .triple_done(triple_done)
  );

  clut_table #(.IDX_W(8), .COMP_W(8), .NCOMP(3)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .sel(tbl_sel),
    .widx(tbl_idx), .wval(tbl_val), .ridx(pix_idx), .rdata(pix_rgb)
  );
endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        idx_wr,
  input logic        comp_wr,
  input logic        triple_done,
  input logic [7:0]  cur_idx,
  input logic [1:0]  cur_phase
);
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (cur_idx == $past(bus_wdata[31:24])) && (cur_phase == 2'd0));

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_wr && !idx_wr && cur_phase < 2'd2) |=>
      (cur_phase == $past(cur_phase) + 2'd1) && $stable(cur_idx));

  a_r3_index_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (triple_done && !idx_wr) |=>
      (cur_phase == 2'd0) && (cur_idx == $past(cur_idx) + 8'd1));

  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_phase != 2'd3);

  a_r5_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> (bus_rdata == 32'd0));

  a_r5_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> $stable(cur_idx) && $stable(cur_phase));

  a_r6_other_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr != 4'h0 && bus_addr != 4'h4) |=>
      $stable(cur_idx) && $stable(cur_phase));
endmodule

bind clut_loader clut_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .idx_wr(idx_wr), .comp_wr(comp_wr), .triple_done(triple_done),
  .cur_idx(cur_idx), .cur_phase(cur_phase)
);

// File: tb/clut_loader_test.sv
module clut_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R4";
  bit    done = 1'b0;

  // behavioural model
  int m_r[256], m_g[256], m_b[256];
  int m_idx, m_ph;
  int exp_rgb;

  always #10ns clk = ~clk;

  clut_loader uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 256; e++) begin
        m_r[e] = (e == 255) ? 255 : 0;
        m_g[e] = m_r[e];
        m_b[e] = m_r[e];
      end
      m_idx = 0; m_ph = 0; exp_rgb = 0;
    end else begin
      // R7/R8: the lookup sees the table before this edge's write
      exp_rgb = (m_r[pix_idx] << 16) | (m_g[pix_idx] << 8) | m_b[pix_idx];
      if (bus_valid && bus_write) begin
        if (bus_addr == 4'h0) begin
          m_idx = bus_wdata[31:24]; m_ph = 0;
        end else if (bus_addr == 4'h4) begin
          if (m_ph == 0) m_r[m_idx] = bus_wdata[31:24];
          else if (m_ph == 1) m_g[m_idx] = bus_wdata[31:24];
          else m_b[m_idx] = bus_wdata[31:24];
          if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
          else m_ph = m_ph + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    #5ns;
    if (rst_n && !done) begin
      n_cmp++;
      if (pix_rgb !== 24'(exp_rgb)) begin
        n_bad++;
        $display("FAIL %s pix_rgb idx-seen actual=%06h expected=%06h",
                 cur_req, pix_rgb, 24'(exp_rgb));
      end
      if (bus_valid && !bus_write) begin
        n_cmp++;
        if (bus_rdata !== 32'd0) begin
          n_bad++;
          $display("FAIL R5 bus_rdata actual=%08h expected=00000000", bus_rdata);
        end
      end
    end
  end

  task automatic cyc(input bit v, input bit w, input logic [3:0] a,
                     input logic [31:0] d, input logic [7:0] p);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; pix_idx = p;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] b, input logic [7:0] p);
    cyc(1'b1, 1'b1, a, {b, 24'hA5C3_5A}, p);
  endtask

  task automatic idle(input logic [7:0] p);
    cyc(1'b0, 1'b0, 4'h0, 32'h0, p);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R4: reset contents, including white entry 255
    cur_req = "R4";
    for (int e = 0; e < 256; e++) idle(8'(e));
    idle(8'd255); idle(8'd0);
    // R4/R2: first components go to entry 0 red, green, blue
    cur_req = "R2";
    wr(4'h4, 8'h11, 8'd0); wr(4'h4, 8'h22, 8'd0); wr(4'h4, 8'h33, 8'd0);
    idle(8'd0); idle(8'd0); idle(8'd1);
    // R1: index load, low data bits ignored; R3 increment to next entry
    cur_req = "R1";
    wr(4'h0, 8'h12, 8'h12);
    wr(4'h4, 8'hA1, 8'h12); wr(4'h4, 8'hA2, 8'h12); wr(4'h4, 8'hA3, 8'h12);
    cur_req = "R3";
    wr(4'h4, 8'hB1, 8'h13); wr(4'h4, 8'hB2, 8'h13); wr(4'h4, 8'hB3, 8'h13);
    idle(8'h13); idle(8'h12); idle(8'h14);
    // R3 wrap 255 -> 0, R8 lookup held on written entry
    cur_req = "R8";
    wr(4'h0, 8'hFF, 8'hFF);
    wr(4'h4, 8'h01, 8'hFF); wr(4'h4, 8'h02, 8'hFF); wr(4'h4, 8'h03, 8'hFF);
    wr(4'h4, 8'h44, 8'h00); wr(4'h4, 8'h55, 8'h00); wr(4'h4, 8'h66, 8'h00);
    idle(8'hFF); idle(8'h00); idle(8'h01);
    // R9: index write mid-sequence restarts at red
    cur_req = "R9";
    wr(4'h0, 8'h40, 8'h40); wr(4'h4, 8'h77, 8'h40); wr(4'h4, 8'h78, 8'h40);
    wr(4'h0, 8'h41, 8'h41); wr(4'h4, 8'h99, 8'h41);
    idle(8'h40); idle(8'h41); idle(8'h41);
    // R5: reads between components return zero and do not advance
    cur_req = "R5";
    wr(4'h0, 8'h50, 8'h50);
    cyc(1'b1, 1'b0, 4'h4, 32'hFFFF_FFFF, 8'h50);
    wr(4'h4, 8'hC1, 8'h50);
    cyc(1'b1, 1'b0, 4'h0, 32'h1234_5678, 8'h50);
    cyc(1'b1, 1'b0, 4'h8, 32'h0, 8'h50);
    wr(4'h4, 8'hC2, 8'h50); wr(4'h4, 8'hC3, 8'h50);
    idle(8'h50); idle(8'h51);
    // R6: other offsets have no effect on table, index or phase
    cur_req = "R6";
    wr(4'h0, 8'h60, 8'h60); wr(4'h4, 8'hD1, 8'h60);
    wr(4'h8, 8'hEE, 8'h60); wr(4'hC, 8'hEE, 8'h60); wr(4'h1, 8'hEE, 8'h60);
    wr(4'h4, 8'hD2, 8'h60); wr(4'h5, 8'hEE, 8'h60); wr(4'h4, 8'hD3, 8'h60);
    idle(8'h60); idle(8'h61); idle(8'h61);
    // R7: random mix, lookup often aimed at the live index
    cur_req = "R7";
    for (int k = 0; k < 2000; k++) begin
      automatic int r = $urandom_range(0, 15);
      automatic logic [3:0] a = (r < 2) ? 4'h0 : (r < 10) ? 4'h4 :
                                (r < 12) ? 4'h8 : 4'hC;
      automatic logic [7:0] p = ($urandom_range(0, 1) != 0) ? 8'(m_idx)
                                                           : 8'($urandom);
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 4) != 0, a,
          $urandom, p);
    end
    idle(8'd0); idle(8'd0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule